// File: doc/BRIEF.md
# Audio Port Status and Interrupt Unit

This unit keeps the status word of a serial audio port and turns it into one interrupt request. The receiver and transmitter send it short event pulses: a new received sample, a receive overrun on any of up to eight time-slot channels, and a transmit underrun on any of those channels. It also shows a few live conditions: receiver on, transmitter on, and transmit space free. Software reads and writes the unit over a plain single-cycle register bus, with word addresses.

Overrun and underrun are sticky. Each has an aggregate flag and a separate per-channel vector. Software can clear any of these flags by writing ones to a clear address, and can force any of them by writing ones to a set address. The receive-ready flag is cleared when software reads the received sample from the holding address. Interrupt sources are enabled through a write-ones-to-enable address and disabled through a write-ones-to-disable address, and the resulting mask can be read back. The request output is registered.

Top module: `audio_stat_irq`

## Requirements
- R1: Status bits 0 (receiver on), 4 (transmitter on) and 5 (transmit space) always show the inputs `rx_on`, `tx_on` and `tx_space`. Writes to the clear or set address do not change them.
- R2: A `rx_got` pulse sets status bit 1. A read at address 6 returns `rx_sample` and clears bit 1 at the clock edge that ends the read.
- R3: If `rx_got` arrives in the same cycle as a read of address 6, status bit 1 stays set.
- R4: A pulse on `rx_ovr_ch[c]` sets status bit 2 and bit 8+c. A pulse on `tx_und_ch[c]` sets status bit 6 and bit 20+c.
- R5: Writing ones to address 1 clears the matching flags among bits 2, 6, 15:8 and 27:20. Flags written with zeros are unchanged.
- R6: Writing ones to address 2 sets the matching flags among bits 2, 6, 15:8 and 27:20. Ones in bits 0, 1, 4 and 5 have no effect.
- R7: If a hardware event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R8: Writing ones to address 3 enables interrupt sources and writing ones to address 4 disables them. Only bits 1, 2, 5 and 6 exist. The mask reads back at address 5.
- R9: `irq` is high exactly one cycle after a cycle in which some status bit among 1, 2, 5 and 6 was set with its mask bit enabled. Otherwise it is low.
- R10: After reset, all sticky flags, the mask and `irq` are zero. The status reads back only the live bits.
- R11: Writes to the read-only addresses 0, 5 and 6 change neither the status nor the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_on | input | 1 | Receiver is running (live) |
| tx_on | input | 1 | Transmitter is running (live) |
| tx_space | input | 1 | Transmitter can accept a sample (live) |
| rx_got | input | 1 | Pulse: a new sample was received |
| rx_sample | input | DW | Sample currently held by the receiver |
| rx_ovr_ch | input | NCH | Pulse per channel: receive overrun |
| tx_und_ch | input | NCH | Pulse per channel: transmit underrun |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| irq | output | 1 | Registered interrupt request |

## Verification
Two kinds of collision can fall in the same cycle. In the first, a hardware event sets a sticky error flag while a software write clears that same flag. In the second, a new sample arrives while software reads the holding address. The bench drives both in one low clock phase: a per-channel overrun pulse together with a clear write covering that aggregate bit and that channel bit, and then `rx_got` together with a holding-address read. Both cases pass only if the flag still reads set after the edge, and the same read must still return the presented sample.

// File: rtl/asi_pkg.sv
package asi_pkg;
    localparam int STAT_W   = 32;
    localparam int RX_ON_B  = 0;
    localparam int RX_RDY_B = 1;
    localparam int RX_OVR_B = 2;
    localparam int TX_ON_B  = 4;
    localparam int TX_SPC_B = 5;
    localparam int TX_UND_B = 6;
    localparam int RXCH_LSB = 8;
    localparam int TXCH_LSB = 20;
    localparam int CH_MAX   = 8;
    localparam int NSRC     = 4;

    typedef enum logic [2:0] {
        A_STAT  = 3'd0,
        A_CLR   = 3'd1,
        A_SET   = 3'd2,
        A_IEN   = 3'd3,
        A_IDIS  = 3'd4,
        A_IMASK = 3'd5,
        A_HOLD  = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic tx_und;
        logic tx_spc;
        logic rx_ovr;
        logic rx_rdy;
    } irq_src_t;

    function automatic irq_src_t src_from_word(input logic [STAT_W-1:0] w);
        irq_src_t s;
        s.tx_und = w[TX_UND_B];
        s.tx_spc = w[TX_SPC_B];
        s.rx_ovr = w[RX_OVR_B];
        s.rx_rdy = w[RX_RDY_B];
        return s;
    endfunction

    function automatic logic [STAT_W-1:0] word_from_src(input irq_src_t s);
        logic [STAT_W-1:0] w;
        w = '0;
        w[TX_UND_B] = s.tx_und;
        w[TX_SPC_B] = s.tx_spc;
        w[RX_OVR_B] = s.rx_ovr;
        w[RX_RDY_B] = s.rx_rdy;
        return w;
    endfunction
endpackage

// File: rtl/asi_flag_bank.sv
module asi_flag_bank #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] hw_set,
    input  logic [W-1:0] sw_clr,
    input  logic [W-1:0] sw_set,
    output logic [W-1:0] flags
);
    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~sw_clr) | sw_set | hw_set;
    end
endmodule

// File: rtl/asi_mask_reg.sv
module asi_mask_reg
    import asi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     en_wr,
    input  logic     dis_wr,
    input  irq_src_t bits,
    output irq_src_t mask
);
    irq_src_t add_v, del_v;
    always_comb begin
        add_v = en_wr  ? bits : '0;
        del_v = dis_wr ? bits : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) mask <= '0;
        else     mask <= (mask | add_v) & ~del_v;
    end
endmodule

// File: rtl/asi_irq_gen.sv
module asi_irq_gen
    import asi_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  irq_src_t src,
    input  irq_src_t mask,
    output logic     irq
);
    always_ff @(posedge clk) begin
        if (rst) irq <= 1'b0;
        else     irq <= |(src & mask);
    end
endmodule

// File: rtl/audio_stat_irq.sv
module audio_stat_irq
    import asi_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 3,
    parameter int DW  = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_on,
    input  logic              tx_on,
    input  logic              tx_space,
    input  logic              rx_got,
    input  logic [DW-1:0]     rx_sample,
    input  logic [NCH-1:0]    rx_ovr_ch,
    input  logic [NCH-1:0]    tx_und_ch,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [AW-1:0]     bus_addr,
    input  logic [STAT_W-1:0] bus_wdata,
    output logic [STAT_W-1:0] bus_rdata,
    output logic              irq
);
    localparam int FW = NCH + 1;

    function automatic logic hit(input logic [AW-1:0] a, input reg_sel_e s);
        return a == AW'(s);
    endfunction

    logic clr_wr, set_wr, ien_wr, idis_wr, pop;
    always_comb begin
        clr_wr  = bus_wr && hit(bus_addr, A_CLR);
        set_wr  = bus_wr && hit(bus_addr, A_SET);
        ien_wr  = bus_wr && hit(bus_addr, A_IEN);
        idis_wr = bus_wr && hit(bus_addr, A_IDIS);
        pop     = bus_rd && hit(bus_addr, A_HOLD);
    end

    // Error field of the write word for each direction: {channels, aggregate}
    logic [FW-1:0] rx_field, tx_field;
    logic [FW-1:0] rx_flags, tx_flags;
    assign rx_field = {bus_wdata[RXCH_LSB +: NCH], bus_wdata[RX_OVR_B]};
    assign tx_field = {bus_wdata[TXCH_LSB +: NCH], bus_wdata[TX_UND_B]};

    logic unused_wbits;
    assign unused_wbits = ^bus_wdata;

    asi_flag_bank #(.W(FW)) u_rx_err (
        .clk    (clk),
        .rst    (rst),
        .hw_set ({rx_ovr_ch, |rx_ovr_ch}),
        .sw_clr (clr_wr ? rx_field : '0),
        .sw_set (set_wr ? rx_field : '0),
        .flags  (rx_flags)
    );

    asi_flag_bank #(.W(FW)) u_tx_err (
        .clk    (clk),
        .rst    (rst),
        .hw_set ({tx_und_ch, |tx_und_ch}),
        .sw_clr (clr_wr ? tx_field : '0),
        .sw_set (set_wr ? tx_field : '0),
        .flags  (tx_flags)
    );

    // Receive-ready: a new sample beats a concurrent read
    logic rdy_q;
    always_ff @(posedge clk) begin
        if (rst) rdy_q <= 1'b0;
        else     rdy_q <= rx_got | (rdy_q & ~pop);
    end

    logic [STAT_W-1:0] stat;
    always_comb begin
        stat = '0;
        stat[RX_ON_B]  = rx_on;
        stat[RX_RDY_B] = rdy_q;
        stat[RX_OVR_B] = rx_flags[0];
        stat[TX_ON_B]  = tx_on;
        stat[TX_SPC_B] = tx_space;
        stat[TX_UND_B] = tx_flags[0];
        stat[RXCH_LSB +: NCH] = rx_flags[FW-1:1];
        stat[TXCH_LSB +: NCH] = tx_flags[FW-1:1];
    end

    irq_src_t mask_q, live_src;
    assign live_src = src_from_word(stat);

    asi_mask_reg u_mask (
        .clk    (clk),
        .rst    (rst),
        .en_wr  (ien_wr),
        .dis_wr (idis_wr),
        .bits   (src_from_word(bus_wdata)),
        .mask   (mask_q)
    );

    asi_irq_gen u_irq (
        .clk  (clk),
        .rst  (rst),
        .src  (live_src),
        .mask (mask_q),
        .irq  (irq)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (hit(bus_addr, A_STAT))  bus_rdata = stat;
            if (hit(bus_addr, A_IMASK)) bus_rdata = word_from_src(mask_q);
            if (hit(bus_addr, A_HOLD))  bus_rdata = STAT_W'(rx_sample);
        end
    end
endmodule

// File: rtl/asi_checker.sv
module asi_checker
    import asi_pkg::*;
#(
    parameter int NCH = 8,
    parameter int AW  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [STAT_W-1:0] stat,
    input irq_src_t          mask_q,
    input logic              irq,
    input logic              rx_got,
    input logic [NCH-1:0]    rx_ovr_ch,
    input logic [NCH-1:0]    tx_und_ch,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [AW-1:0]     bus_addr,
    input logic [STAT_W-1:0] bus_wdata
);
    logic pending, hold_rd, clr_ovr;
    assign pending = |(src_from_word(stat) & mask_q);
    assign hold_rd = bus_rd && bus_addr == AW'(A_HOLD);
    assign clr_ovr = bus_wr && bus_addr == AW'(A_CLR) && bus_wdata[RX_OVR_B];

    a_r9_irq_rise: assert property (@(posedge clk) disable iff (rst)
        pending |=> irq);
    a_r9_irq_fall: assert property (@(posedge clk) disable iff (rst)
        !pending |=> !irq);
    a_r3_rdy_wins: assert property (@(posedge clk) disable iff (rst)
        rx_got |=> stat[RX_RDY_B]);
    a_r2_pop_clears: assert property (@(posedge clk) disable iff (rst)
        (hold_rd && !rx_got) |=> !stat[RX_RDY_B]);
    a_r7_ovr_wins: assert property (@(posedge clk) disable iff (rst)
        (|rx_ovr_ch) |=> stat[RX_OVR_B]);
    a_r7_und_wins: assert property (@(posedge clk) disable iff (rst)
        (|tx_und_ch) |=> stat[TX_UND_B]);
    a_r5_clear_ovr: assert property (@(posedge clk) disable iff (rst)
        (clr_ovr && !(|rx_ovr_ch)) |=> !stat[RX_OVR_B]);
    a_r10_reset_quiet: assert property (@(posedge clk)
        $past(rst) |-> (!irq && mask_q == '0));
endmodule

bind audio_stat_irq asi_checker #(.NCH(NCH), .AW(AW)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .stat      (stat),
    .mask_q    (mask_q),
    .irq       (irq),
    .rx_got    (rx_got),
    .rx_ovr_ch (rx_ovr_ch),
    .tx_und_ch (tx_und_ch),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/sim_audio_stat_irq.sv
module sim_audio_stat_irq;
    localparam int NCH = 8;
    localparam int AW  = 3;
    localparam int DW  = 32;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rx_on = 0, tx_on = 0, tx_space = 0, rx_got = 0;
    logic [DW-1:0]  rx_sample = '0;
    logic [NCH-1:0] rx_ovr_ch = '0, tx_und_ch = '0;
    logic bus_wr = 0, bus_rd = 0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    audio_stat_irq #(.NCH(NCH), .AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst(rst), .rx_on(rx_on), .tx_on(tx_on), .tx_space(tx_space),
        .rx_got(rx_got), .rx_sample(rx_sample), .rx_ovr_ch(rx_ovr_ch),
        .tx_und_ch(tx_und_ch), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Read without crossing a clock edge (no side effect)
    task automatic peek(input logic [AW-1:0] a, output logic [31:0] v);
        bus_addr = a; bus_rd = 1;
        #1 v = bus_rdata;
        bus_rd = 0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk);
        bus_wr = 0; bus_wdata = '0;
    endtask

    task automatic pulse_ovr(input logic [NCH-1:0] r, input logic [NCH-1:0] t);
        @(negedge clk);
        rx_ovr_ch = r; tx_und_ch = t;
        @(negedge clk);
        rx_ovr_ch = '0; tx_und_ch = '0;
    endtask

    task automatic t_reset;
        logic [31:0] v;
        peek(3'd0, v); check("R10 status", v, 32'h0);
        peek(3'd5, v); check("R10 mask", v, 32'h0);
        check("R10 irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_live;
        logic [31:0] v;
        @(negedge clk);
        rx_on = 1; tx_on = 1; tx_space = 1;
        peek(3'd0, v); check("R1 live bits", v, 32'h31);
        wr(3'd1, 32'hFFFF_FFFF);
        peek(3'd0, v); check("R1 after clear", v, 32'h31);
        wr(3'd2, 32'h0000_0033);
        peek(3'd0, v); check("R6 set ignores live", v, 32'h31);
        rx_on = 0; tx_on = 0; tx_space = 0;
        #1 peek(3'd0, v); check("R1 live low", v, 32'h0);
    endtask

    task automatic t_events;
        logic [31:0] v;
        pulse_ovr(8'h05, 8'h00);
        peek(3'd0, v); check("R4 overrun ch0 ch2", v, 32'h0000_0504);
        pulse_ovr(8'h00, 8'h80);
        peek(3'd0, v); check("R4 underrun ch7", v, 32'h0800_0544);
        wr(3'd1, 32'h0000_0104);
        peek(3'd0, v); check("R5 partial clear", v, 32'h0800_0440);
        wr(3'd1, 32'hFFFF_FFFF);
        peek(3'd0, v); check("R5 clear all", v, 32'h0);
        wr(3'd2, 32'h0030_0044);
        peek(3'd0, v); check("R6 set flags", v, 32'h0030_0044);
        wr(3'd0, 32'hFFFF_FFFF);
        peek(3'd0, v); check("R11 status write ignored", v, 32'h0030_0044);
        wr(3'd1, 32'hFFFF_FFFF);
    endtask

    task automatic t_collide_err;
        logic [31:0] v;
        @(negedge clk);
        rx_ovr_ch = 8'h02;
        bus_addr = 3'd1; bus_wdata = 32'h0000_0204; bus_wr = 1;
        @(negedge clk);
        rx_ovr_ch = '0; bus_wr = 0; bus_wdata = '0;
        peek(3'd0, v); check("R7 set beats clear", v, 32'h0000_0204);
        wr(3'd1, 32'hFFFF_FFFF);
    endtask

    task automatic t_rx_ready;
        logic [31:0] v;
        @(negedge clk);
        rx_sample = 32'h0000_ABCD; rx_got = 1;
        @(negedge clk);
        rx_got = 0;
        peek(3'd0, v); check("R2 ready set", v, 32'h2);
        bus_addr = 3'd6; bus_rd = 1;
        #1 check("R2 holding data", bus_rdata, 32'h0000_ABCD);
        @(negedge clk);
        bus_rd = 0;
        peek(3'd0, v); check("R2 ready cleared by read", v, 32'h0);
        // arrival and read in the same cycle
        @(negedge clk);
        rx_sample = 32'h0000_1234; rx_got = 1;
        bus_addr = 3'd6; bus_rd = 1;
        #1 check("R3 holding data", bus_rdata, 32'h0000_1234);
        @(negedge clk);
        rx_got = 0; bus_rd = 0;
        peek(3'd0, v); check("R3 ready kept", v, 32'h2);
        @(negedge clk);
        bus_addr = 3'd6; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
        peek(3'd0, v); check("R2 drained", v, 32'h0);
    endtask

    task automatic t_mask_irq;
        logic [31:0] v;
        wr(3'd3, 32'hFFFF_FFFF);
        peek(3'd5, v); check("R8 enable all", v, 32'h66);
        wr(3'd4, 32'h0000_0004);
        peek(3'd5, v); check("R8 disable overrun", v, 32'h62);
        wr(3'd5, 32'h0);
        peek(3'd5, v); check("R11 mask write ignored", v, 32'h62);
        check("R9 idle irq low", {31'h0, irq}, 32'h0);
        pulse_ovr(8'h10, 8'h00);
        @(negedge clk);
        check("R9 masked overrun no irq", {31'h0, irq}, 32'h0);
        @(negedge clk);
        tx_und_ch = 8'h01;
        @(negedge clk);
        tx_und_ch = '0;
        check("R9 irq not yet", {31'h0, irq}, 32'h0);
        @(negedge clk);
        check("R9 irq one cycle later", {31'h0, irq}, 32'h1);
        wr(3'd1, 32'h0010_0040);
        check("R9 irq still high", {31'h0, irq}, 32'h1);
        @(negedge clk);
        check("R9 irq drops", {31'h0, irq}, 32'h0);
        tx_space = 1;
        @(negedge clk);
        check("R9 live tx space irq", {31'h0, irq}, 32'h1);
        tx_space = 0;
        wr(3'd1, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset();
        t_live();
        t_events();
        t_collide_err();
        t_rx_ready();
        t_mask_irq();
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0;
        t_reset();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule